// File: doc/BRIEF.md
# Circular Audio DMA Address Engine

This block produces the memory addresses for a streaming audio FIFO. It walks a circular buffer in memory one fixed 8-byte burst at a time. It asks for each burst through a request/acknowledge handshake, and only when the FIFO holds enough data. It counts the bursts that complete and raises a repeating interrupt every programmed number of bursts. It also flags each return of the pointer to the start of the buffer.

Software programs the block through a small word-indexed register port. The registers hold the buffer bounds, the first address, the interrupt period, the request threshold, the run and interrupt-enable bits, and the interrupt clears. One status register shows the sticky interrupt flags. A second status register shows a value chosen by a select field.

The buffer bounds are inclusive: the finish register holds the address of the last burst, not the end of the buffer. The threshold is written as a burst count minus one. An interrupt clear stays in force until software writes it back to zero.

Top module: `aud_ring_dma`

## Requirements
- R1: After reset, `req_valid` and `irq` are low, and the control register (index 0) and the flag register (index 7) read as zero.
- R2: While the run bit (control register, bit 0) is clear, `req_valid` stays low whatever the FIFO level is.
- R3: On the first setting of the run bit after reset, the pointer loads from the initial-address register (index 4). All address registers (indices 2, 3, 4) drop their three low bits, and those bits read back as zero.
- R4: Each accepted burst (`req_valid` and `req_ack` high on the same edge) moves `req_addr` on by 8 bytes. Clearing the run bit and then setting it again resumes from the current pointer; the pointer does not reload.
- R5: After the burst at the finish address (index 3) is accepted, the next address is the start address (index 2).
- R6: `req_valid` is high only when the run bit is set and `fifo_lvl` is at least the threshold register (index 6) plus one.
- R7: The period register (index 5) holds a burst count N. When N bursts have completed, flag bit 0 sets and the count restarts, so the flag sets again after every further N bursts. A period of 0 never sets the flag.
- R8: Flag bit 1 sets when the pointer wraps from the finish address to the start address.
- R9: While clear bit i (control-1 register, index 1, bits 1:0) is held at 1, flag bit i reads 0. A set event in the same cycle as a held clear still sets the flag for that cycle.
- R10: `irq` is high exactly when some flag bit is set and its enable (control register, bits 9:8) is set.
- R11: Status-2 (index 8) shows the current burst address when the select field (control-1, bits 5:4) is 0, and the number of bursts counted in the current period when the select field is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| fifo_lvl | input | LVL_W | FIFO occupancy in bursts |
| req_valid | output | 1 | Burst request |
| req_addr | output | ADDR_W | Byte address of the requested burst |
| req_ack | input | 1 | Burst accepted |
| irq | output | 1 | Interrupt line |

## Verification
On every cycle the assertions check four things: no request without the run bit, no request below the threshold, a one-burst step or a wrap to the start after each accepted burst, and the set and clear rules of the sticky flags. The bench scenarios cover what a single cycle cannot show: loading from the initial address on the first run, resuming without reload after a stop, the periodic firing of the count flag and its absence with a zero period, readback with the low address bits dropped, and the status-2 select choices.

// File: rtl/aud_dma_pkg.sv
package aud_dma_pkg;

    localparam int NSRC     = 2;
    localparam int SRC_REP  = 0;
    localparam int SRC_WRAP = 1;
    localparam int IEN_LSB  = 8;

    typedef enum logic [3:0] {
        RA_CTRL   = 4'd0,
        RA_CTRL1  = 4'd1,
        RA_START  = 4'd2,
        RA_FINISH = 4'd3,
        RA_INIT   = 4'd4,
        RA_PERIOD = 4'd5,
        RA_THRESH = 4'd6,
        RA_STAT1  = 4'd7,
        RA_STAT2  = 4'd8
    } reg_idx_e;

    typedef enum logic [1:0] {
        S2_ADDR  = 2'd0,
        S2_COUNT = 2'd1,
        S2_LEVEL = 2'd2,
        S2_ZERO  = 2'd3
    } s2_sel_e;

    typedef struct packed {
        logic [NSRC-1:0] ien;
        logic            run;
    } ctrl0_t;

    typedef struct packed {
        s2_sel_e         sel;
        logic [NSRC-1:0] clr;
    } ctrl1_t;

    function automatic ctrl0_t unpack_ctrl0(input logic [31:0] w);
        ctrl0_t c;
        c.run = w[0];
        c.ien = w[IEN_LSB +: NSRC];
        return c;
    endfunction

    function automatic ctrl1_t unpack_ctrl1(input logic [31:0] w);
        ctrl1_t c;
        c.clr = w[NSRC-1:0];
        c.sel = s2_sel_e'(w[5:4]);
        return c;
    endfunction

endpackage

// File: rtl/aud_dma_regs.sv
module aud_dma_regs
    import aud_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BOFS   = 3,
    parameter int CNT_W  = 16,
    parameter int LVL_W  = 8,
    localparam int PTR_W = ADDR_W - BOFS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [3:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic [NSRC-1:0]  status,
    input  logic [PTR_W-1:0] cur_ptr,
    input  logic [CNT_W-1:0] burst_cnt,
    input  logic [LVL_W-1:0] fifo_lvl,
    output ctrl0_t           c0,
    output ctrl1_t           c1,
    output logic [PTR_W-1:0] start_p,
    output logic [PTR_W-1:0] finish_p,
    output logic [PTR_W-1:0] init_p,
    output logic [CNT_W-1:0] period,
    output logic [LVL_W-1:0] thresh,
    output logic             run_rise
);

    reg_idx_e idx;
    assign idx = reg_idx_e'(addr);

    assign run_rise = wr && (idx == RA_CTRL) && wdata[0] && !c0.run;

    always_ff @(posedge clk) begin
        if (rst) begin
            c0       <= '0;
            c1       <= '0;
            start_p  <= '0;
            finish_p <= '0;
            init_p   <= '0;
            period   <= '0;
            thresh   <= '0;
        end else if (wr) begin
            case (idx)
                RA_CTRL:   c0       <= unpack_ctrl0(wdata);
                RA_CTRL1:  c1       <= unpack_ctrl1(wdata);
                RA_START:  start_p  <= wdata[ADDR_W-1:BOFS];
                RA_FINISH: finish_p <= wdata[ADDR_W-1:BOFS];
                RA_INIT:   init_p   <= wdata[ADDR_W-1:BOFS];
                RA_PERIOD: period   <= wdata[CNT_W-1:0];
                RA_THRESH: thresh   <= wdata[LVL_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (idx)
            RA_CTRL: begin
                rdata[0]                = c0.run;
                rdata[IEN_LSB +: NSRC]  = c0.ien;
            end
            RA_CTRL1: begin
                rdata[NSRC-1:0] = c1.clr;
                rdata[5:4]      = 2'(c1.sel);
            end
            RA_START:  rdata[ADDR_W-1:0] = {start_p,  {BOFS{1'b0}}};
            RA_FINISH: rdata[ADDR_W-1:0] = {finish_p, {BOFS{1'b0}}};
            RA_INIT:   rdata[ADDR_W-1:0] = {init_p,   {BOFS{1'b0}}};
            RA_PERIOD: rdata[CNT_W-1:0]  = period;
            RA_THRESH: rdata[LVL_W-1:0]  = thresh;
            RA_STAT1:  rdata[NSRC-1:0]   = status;
            RA_STAT2: begin
                case (c1.sel)
                    S2_ADDR:  rdata[ADDR_W-1:0] = {cur_ptr, {BOFS{1'b0}}};
                    S2_COUNT: rdata[CNT_W-1:0]  = burst_cnt;
                    S2_LEVEL: rdata[LVL_W-1:0]  = fifo_lvl;
                    default:  rdata = '0;
                endcase
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/aud_dma_walk.sv
module aud_dma_walk
    import aud_dma_pkg::*;
#(
    parameter int PTR_W = 29,
    parameter int CNT_W = 16,
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             run_rise,
    input  logic [PTR_W-1:0] start_p,
    input  logic [PTR_W-1:0] finish_p,
    input  logic [PTR_W-1:0] init_p,
    input  logic [CNT_W-1:0] period,
    input  logic [LVL_W-1:0] thresh,
    input  logic [LVL_W-1:0] fifo_lvl,
    input  logic             req_ack,
    output logic             req_valid,
    output logic [PTR_W-1:0] cur_ptr,
    output logic [CNT_W-1:0] burst_cnt,
    output logic [NSRC-1:0]  set_evt
);

    logic             need_load;
    logic             fire;
    logic             at_end;
    logic             period_hit;
    logic [CNT_W:0]   cnt_inc;

    // threshold register holds bursts minus one: level must exceed it
    assign req_valid  = run && !need_load && (fifo_lvl > thresh);
    assign fire       = req_valid && req_ack;
    assign at_end     = (cur_ptr == finish_p);
    assign cnt_inc    = {1'b0, burst_cnt} + 1'b1;
    assign period_hit = (period != '0) && (cnt_inc == {1'b0, period});

    always_comb begin
        set_evt           = '0;
        set_evt[SRC_REP]  = fire && period_hit;
        set_evt[SRC_WRAP] = fire && at_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_ptr   <= '0;
            burst_cnt <= '0;
            need_load <= 1'b1;
        end else if (run_rise && need_load) begin
            cur_ptr   <= init_p;
            burst_cnt <= '0;
            need_load <= 1'b0;
        end else if (fire) begin
            cur_ptr   <= at_end ? start_p : cur_ptr + 1'b1;
            burst_cnt <= period_hit ? '0 : cnt_inc[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/aud_dma_irq.sv
module aud_dma_irq
    import aud_dma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_evt,
    input  logic [NSRC-1:0] clr,
    input  logic [NSRC-1:0] ien,
    output logic [NSRC-1:0] status,
    output logic            irq
);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)
                status[i] <= 1'b0;
            else
                status[i] <= set_evt[i] | (status[i] & ~clr[i]);
        end
    end

    assign irq = |(status & ien);

endmodule

// File: rtl/aud_ring_dma.sv
module aud_ring_dma
    import aud_dma_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BURST_BYTES = 8,
    parameter int CNT_W       = 16,
    parameter int LVL_W       = 8,
    localparam int BOFS       = $clog2(BURST_BYTES),
    localparam int PTR_W      = ADDR_W - BOFS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [LVL_W-1:0]  fifo_lvl,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              req_ack,
    output logic              irq
);

    ctrl0_t           c0;
    ctrl1_t           c1;
    logic [PTR_W-1:0] start_p, finish_p, init_p, cur_ptr;
    logic [CNT_W-1:0] period, burst_cnt;
    logic [LVL_W-1:0] thresh;
    logic             run_rise;
    logic [NSRC-1:0]  status, set_evt;
    logic             run_w;
    logic [NSRC-1:0]  clr_w;

    assign run_w = c0.run;
    assign clr_w = c1.clr;

    aud_dma_regs #(
        .ADDR_W(ADDR_W), .BOFS(BOFS), .CNT_W(CNT_W), .LVL_W(LVL_W)
    ) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .status(status),
        .cur_ptr(cur_ptr), .burst_cnt(burst_cnt), .fifo_lvl(fifo_lvl),
        .c0(c0), .c1(c1), .start_p(start_p), .finish_p(finish_p),
        .init_p(init_p), .period(period), .thresh(thresh),
        .run_rise(run_rise)
    );

    aud_dma_walk #(
        .PTR_W(PTR_W), .CNT_W(CNT_W), .LVL_W(LVL_W)
    ) u_walk (
        .clk(clk), .rst(rst), .run(run_w), .run_rise(run_rise),
        .start_p(start_p), .finish_p(finish_p), .init_p(init_p),
        .period(period), .thresh(thresh), .fifo_lvl(fifo_lvl),
        .req_ack(req_ack), .req_valid(req_valid), .cur_ptr(cur_ptr),
        .burst_cnt(burst_cnt), .set_evt(set_evt)
    );

    aud_dma_irq u_irq (
        .clk(clk), .rst(rst), .set_evt(set_evt), .clr(clr_w),
        .ien(c0.ien), .status(status), .irq(irq)
    );

    assign req_addr = {cur_ptr, {BOFS{1'b0}}};

endmodule

// File: rtl/aud_dma_chk.sv
module aud_dma_chk
    import aud_dma_pkg::*;
#(
    parameter int PTR_W = 29,
    parameter int LVL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             req_valid,
    input logic             req_ack,
    input logic [PTR_W-1:0] cur_ptr,
    input logic [PTR_W-1:0] start_p,
    input logic [PTR_W-1:0] finish_p,
    input logic [LVL_W-1:0] fifo_lvl,
    input logic [LVL_W-1:0] thresh,
    input logic [NSRC-1:0]  clr,
    input logic [NSRC-1:0]  set_evt,
    input logic [NSRC-1:0]  status
);

    assert_idle_no_req_R2: assert property (@(posedge clk) disable iff (rst)
        !run |-> !req_valid);

    assert_level_gate_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (fifo_lvl > thresh));

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ack && cur_ptr != finish_p)
        |=> cur_ptr == PTR_W'($past(cur_ptr) + 1'b1));

    assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ack && cur_ptr == finish_p)
        |=> cur_ptr == $past(start_p));

    assert_set_R7: assert property (@(posedge clk) disable iff (rst)
        set_evt[SRC_REP] |=> status[SRC_REP]);

    assert_wrapflag_R8: assert property (@(posedge clk) disable iff (rst)
        set_evt[SRC_WRAP] |=> status[SRC_WRAP]);

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr[SRC_REP] && !set_evt[SRC_REP]) |=> !status[SRC_REP]);

endmodule

bind aud_ring_dma aud_dma_chk #(.PTR_W(PTR_W), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .run(run_w), .req_valid(req_valid),
    .req_ack(req_ack), .cur_ptr(cur_ptr), .start_p(start_p),
    .finish_p(finish_p), .fifo_lvl(fifo_lvl), .thresh(thresh),
    .clr(clr_w), .set_evt(set_evt), .status(status)
);

// File: tb/sim_aud_ring_dma.sv
module sim_aud_ring_dma;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [7:0]  fifo_lvl = 8'd0;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        req_ack = 1'b0;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    aud_ring_dma u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_lvl(fifo_lvl),
        .req_valid(req_valid), .req_addr(req_addr), .req_ack(req_ack),
        .irq(irq)
    );

    typedef struct packed {
        logic [7:0] th;
        logic [7:0] lvl;
        logic       exp;
    } tv_t;

    localparam tv_t TV [0:5] = '{
        '{8'd0,   8'd0,   1'b0},
        '{8'd0,   8'd1,   1'b1},
        '{8'd3,   8'd3,   1'b0},
        '{8'd3,   8'd4,   1'b1},
        '{8'd7,   8'd200, 1'b1},
        '{8'd255, 8'd255, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic burst(input string tag, input logic [31:0] exp_addr);
        @(negedge clk);
        chk({tag, " valid"}, {31'd0, req_valid}, 32'd1);
        chk({tag, " addr"}, req_addr, exp_addr);
        req_ack = 1'b1;
        @(negedge clk);
        req_ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 req_valid", {31'd0, req_valid}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(4'd0, d); chk("R1 ctrl", d, 32'd0);
        rd(4'd7, d); chk("R1 flags", d, 32'd0);

        // program buffer: 4 bursts 0x1000..0x1018
        wr(4'd2, 32'h0000_1000);
        wr(4'd3, 32'h0000_101C);
        wr(4'd4, 32'h0000_100F);
        wr(4'd5, 32'd3);
        wr(4'd6, 32'd1);
        rd(4'd4, d); chk("R3 init low bits dropped", d, 32'h0000_1008);
        rd(4'd3, d); chk("R3 finish low bits dropped", d, 32'h0000_1018);
        fifo_lvl = 8'd4;
        repeat (3) @(negedge clk);
        chk("R2 no request while stopped", {31'd0, req_valid}, 32'd0);

        wr(4'd0, 32'h0000_0301);
        chk("R3 first address from init", req_addr, 32'h0000_1008);

        // R6 threshold vector table
        for (int i = 0; i < 6; i++) begin
            wr(4'd6, {24'd0, TV[i].th});
            fifo_lvl = TV[i].lvl;
            @(negedge clk);
            #1 chk($sformatf("R6 vec%0d", i), {31'd0, req_valid}, {31'd0, TV[i].exp});
        end
        wr(4'd6, 32'd1);
        fifo_lvl = 8'd4;

        burst("R4 b1", 32'h0000_1008);
        burst("R4 b2", 32'h0000_1010);
        rd(4'd7, d); chk("R7 no flag before period", d, 32'd0);
        burst("R5 b3", 32'h0000_1018);
        rd(4'd7, d); chk("R7 R8 flags after period and wrap", d, 32'd3);
        chk("R10 irq with flags enabled", {31'd0, irq}, 32'd1);
        rd(4'd8, d); chk("R11 status2 address", d, 32'h0000_1000);

        // R9 held clear on the count flag
        wr(4'd1, 32'h0000_0001);
        rd(4'd7, d); chk("R9 count flag cleared", d, 32'd2);
        chk("R10 irq from wrap flag", {31'd0, irq}, 32'd1);
        wr(4'd0, 32'h0000_0101);
        chk("R10 irq off with wrap disabled", {31'd0, irq}, 32'd0);

        burst("R5 b4 wrapped", 32'h0000_1000);
        wr(4'd1, 32'h0000_0011);
        rd(4'd8, d); chk("R11 status2 count", d, 32'd1);
        burst("R4 b5", 32'h0000_1008);
        reg_addr = 4'd7;
        burst("R4 b6", 32'h0000_1010);
        #1 chk("R9 set wins over held clear", reg_rdata & 32'd1, 32'd1);
        chk("R10 irq on count flag", {31'd0, irq}, 32'd1);
        @(negedge clk);
        #1 chk("R9 held clear removes flag", reg_rdata & 32'd1, 32'd0);
        chk("R10 irq after clear", {31'd0, irq}, 32'd0);
        wr(4'd1, 32'h0000_0000);

        // R4 stop then resume from current pointer
        wr(4'd0, 32'h0000_0100);
        chk("R2 stopped", {31'd0, req_valid}, 32'd0);
        repeat (2) @(negedge clk);
        chk("R2 still stopped", {31'd0, req_valid}, 32'd0);
        wr(4'd0, 32'h0000_0101);
        chk("R4 resume without reload", req_addr, 32'h0000_1018);

        // R7 period zero never fires
        wr(4'd5, 32'd0);
        burst("R5 p0 a", 32'h0000_1018);
        burst("R5 p0 b", 32'h0000_1000);
        burst("R4 p0 c", 32'h0000_1008);
        burst("R4 p0 d", 32'h0000_1010);
        burst("R4 p0 e", 32'h0000_1018);
        rd(4'd7, d); chk("R7 period zero no count flag", d & 32'd1, 32'd0);
        chk("R8 wrap flag set again", d & 32'd2, 32'd2);

        finish_run();
    end

endmodule